// File: doc/BRIEF.md
# Trace and Format-Error Exception Sequencer

This block sits next to the retire stage of a small processor core and decides, for every retiring instruction, whether a trace exception or a format-error exception has to be taken. Each retire event carries the instruction class, the address of the instruction itself and the address of the one that would follow. It also carries, for the stop instruction, the status-register value that instruction loads. A format-check failure strobe and the status register in force when the instruction began come in alongside.

When an exception is due, the block latches a copy of the relevant status-register value, the stacked address and the vector number. It then writes a three-word frame to a supervisor stack port, one word per cycle. With the first word it publishes the new live status register: supervisor set, tracing switched off. After the last word it pulses a redirect request that carries the vector number, so the fetch unit can read the vector table.

A stop instruction that retires with tracing switched off produces a one-cycle pulse asking the core to enter the stopped state. Retire events offered while a frame is in progress are dropped, because the core is expected to stall.

Top module: `trace_fmt_seq`

## Requirements
- R1: After reset, and with no retire event, `stackWe`, `srOutValid`, `redirect`, `stopEnter` and `busy` are all low.
- R2: The trace field is status-register bits 15:14 (bit 15 = T1, bit 14 = T0). Class codes on `retireClass` are 0 normal, 1 change-of-flow, 2 stop, 3 illegal/unimplemented. For normal and change-of-flow classes, the field acts as follows: 2'b10 traces both classes, 2'b01 traces only change-of-flow, and 2'b00 or the reserved 2'b11 trace neither.
- R3: An illegal/unimplemented retire (class 3) never starts a trace exception, whatever the trace field holds.
- R4: An exception accepted at clock edge k writes three words on the next three cycles: index 0 is the status copy, index 1 is the stacked address, index 2 is the vector number times 4. Each word is zero-extended and has `stackWe` high for exactly one cycle. The cycle after that has `redirect` high for one cycle, and `busy` is high from the first word through the redirect.
- R5: A trace exception uses vector 9. It stacks `retireNextPc`, and its status copy is `srIn`.
- R6: With the first frame word, `srOutValid` pulses once. `srOut` equals the status copy with bit 13 (supervisor) set and bits 15:14 cleared, and all other bits are unchanged.
- R7: A stop retire (class 2) whose `srIn` trace field is nonzero never pulses `stopEnter`. It takes a trace exception whose status copy is `stopNewSr`, the value the stop instruction loaded, and whose stacked address is `retireNextPc`.
- R8: A stop retire with trace field 2'b00 and no format error pulses `stopEnter` for one cycle, one cycle after it is accepted, and writes no frame.
- R9: `fmtErr` high together with `retireValid` takes a format-error exception with vector 14. It stacks `retireCurPc`, and its status copy is `srIn`, for every class.
- R10: When a format error and a trace condition occur on the same retire, only the format-error frame (vector 14) is written, and no trace frame follows it.
- R11: Retire events presented while `busy` is high, and `fmtErr` without `retireValid`, have no effect: they change neither the frame in progress nor produce any later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | One instruction retires this cycle |
| retireClass | input | 2 | Class of retiring instruction (0 normal, 1 flow change, 2 stop, 3 illegal) |
| retireNextPc | input | ADDR_W | Address of the following instruction |
| retireCurPc | input | ADDR_W | Address of the retiring instruction |
| stopNewSr | input | 16 | Status value loaded by a retiring stop instruction |
| fmtErr | input | 1 | Format check failed on the retiring instruction |
| srIn | input | 16 | Status register in force when the instruction began |
| stackWe | output | 1 | Supervisor stack write strobe |
| stackIdx | output | 2 | Frame word index (0, 1, 2) |
| stackData | output | DATA_W | Frame word data |
| srOutValid | output | 1 | Load `srOut` into the live status register |
| srOut | output | 16 | New status register value |
| redirect | output | 1 | Fetch from the exception vector |
| redirectVector | output | 8 | Vector number for the redirect |
| stopEnter | output | 1 | Enter the stopped state |
| busy | output | 1 | Frame sequence in progress |

## Verification
The trace decision is tried with every trace-field value crossed with the normal and change-of-flow classes. This separates every-instruction tracing from flow-only tracing, and shows whether the reserved code is treated as off. Illegal retires run with all four field values, and stop retires run untraced, with the reserved code, and with flow-only tracing. These show whether the loaded status value is the one stacked and whether the stopped state is wrongly requested. Format errors are tried alone and combined with an active trace condition, which exposes the wrong stacked address and the wrong priority. Events fired in the middle of a frame, and a bare format strobe, confirm that nothing extra is written.

// File: rtl/tfx_pkg.sv
package tfx_pkg;
  localparam int SR_W      = 16;
  localparam int T1_BIT    = 15;
  localparam int T0_BIT    = 14;
  localparam int S_BIT     = 13;
  localparam int VEC_W     = 8;
  localparam int VEC_TRACE = 9;
  localparam int VEC_FMT   = 14;

  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_FLOW   = 2'd1,
    CLS_STOP   = 2'd2,
    CLS_BAD    = 2'd3
  } retire_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W0,
    ST_W1,
    ST_W2,
    ST_JUMP
  } seq_st_e;

  typedef struct packed {
    logic       capture;
    logic       fmtSel;
    logic       stopSel;
    logic       we;
    logic [1:0] wordIdx;
    logic       srPulse;
    logic       jump;
    logic       stopPulse;
  } seq_ctl_t;
endpackage

// File: rtl/tfx_ctrl.sv
module tfx_ctrl
  import tfx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       retireValid,
  input  logic [1:0] retireClass,
  input  logic       fmtErr,
  input  logic [1:0] traceBits,
  output seq_ctl_t   ctl,
  output logic       busy
);
  seq_st_e     state, stateNext;
  retire_cls_e cls;
  logic        evt, traceHit, wantFmt, wantTrace, wantStop, stopPend;

  assign cls = retire_cls_e'(retireClass);
  assign evt = retireValid && (state == ST_IDLE);

  always_comb begin
    unique case (cls)
      CLS_NORMAL: traceHit = (traceBits == 2'b10);
      CLS_FLOW:   traceHit = (traceBits == 2'b10) || (traceBits == 2'b01);
      CLS_STOP:   traceHit = (traceBits != 2'b00);
      default:    traceHit = 1'b0;
    endcase
  end

  assign wantFmt   = evt && fmtErr;
  assign wantTrace = evt && !fmtErr && traceHit;
  assign wantStop  = evt && !fmtErr && (cls == CLS_STOP) && (traceBits == 2'b00);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (wantFmt || wantTrace) stateNext = ST_W0;
      ST_W0:   stateNext = ST_W1;
      ST_W1:   stateNext = ST_W2;
      ST_W2:   stateNext = ST_JUMP;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stopPend <= 1'b0;
    end else begin
      state    <= stateNext;
      stopPend <= wantStop;
    end
  end

  always_comb begin
    ctl.capture   = wantFmt || wantTrace;
    ctl.fmtSel    = wantFmt;
    ctl.stopSel   = (cls == CLS_STOP);
    ctl.we        = (state == ST_W0) || (state == ST_W1) || (state == ST_W2);
    ctl.wordIdx   = (state == ST_W1) ? 2'd1 : (state == ST_W2) ? 2'd2 : 2'd0;
    ctl.srPulse   = (state == ST_W0);
    ctl.jump      = (state == ST_JUMP);
    ctl.stopPulse = stopPend;
  end

  assign busy = (state != ST_IDLE);

  // R4: redirect only right after the last frame word
  p_jump_after_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.jump |-> $past(ctl.we && ctl.wordIdx == 2'd2));

  // R3: an illegal retire without format error starts no frame
  p_bad_no_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    (evt && cls == CLS_BAD && !fmtErr) |=> !ctl.we);

  // R8: the stop pulse never overlaps a frame
  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stopPulse |-> !ctl.we && !ctl.jump);

  // R11: an event during a frame does not restart the sequence
  p_busy_ignores_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctl.jump) |=> busy);
endmodule

// File: rtl/tfx_dp.sv
module tfx_dp
  import tfx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctl_t          ctl,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [SR_W-1:0]   stopSr,
  input  logic [SR_W-1:0]   srIn,
  output logic [DATA_W-1:0] stackData,
  output logic [SR_W-1:0]   srOut,
  output logic [VEC_W-1:0]  vecOut
);
  localparam int OFS_W = VEC_W + 2;

  logic [SR_W-1:0]   copyReg;
  logic [ADDR_W-1:0] pcReg;
  logic [VEC_W-1:0]  vecReg;
  logic [OFS_W-1:0]  vecOfs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      copyReg <= '0;
      pcReg   <= '0;
      vecReg  <= '0;
    end else if (ctl.capture) begin
      copyReg <= ctl.stopSel && !ctl.fmtSel ? stopSr : srIn;
      pcReg   <= ctl.fmtSel ? curPc : nextPc;
      vecReg  <= ctl.fmtSel ? VEC_W'(VEC_FMT) : VEC_W'(VEC_TRACE);
    end
  end

  assign vecOfs = {vecReg, 2'b00};

  always_comb begin
    unique case (ctl.wordIdx)
      2'd0:    stackData = DATA_W'(copyReg);
      2'd1:    stackData = DATA_W'(pcReg);
      default: stackData = DATA_W'(vecOfs);
    endcase
  end

  always_comb begin
    srOut         = copyReg;
    srOut[T1_BIT] = 1'b0;
    srOut[T0_BIT] = 1'b0;
    srOut[S_BIT]  = 1'b1;
  end

  assign vecOut = vecReg;

  // R5 / R9: only the two known vectors are ever issued
  p_vector_known_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.jump |-> (vecOut == VEC_W'(VEC_TRACE) || vecOut == VEC_W'(VEC_FMT)));

  // R4: frame words stay latched while the frame is written
  p_frame_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.we && ctl.wordIdx != 2'd0) |-> $stable(pcReg) && $stable(copyReg));
endmodule

// File: rtl/trace_fmt_seq.sv
module trace_fmt_seq
  import tfx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireValid,
  input  logic [1:0]        retireClass,
  input  logic [ADDR_W-1:0] retireNextPc,
  input  logic [ADDR_W-1:0] retireCurPc,
  input  logic [15:0]       stopNewSr,
  input  logic              fmtErr,
  input  logic [15:0]       srIn,
  output logic              stackWe,
  output logic [1:0]        stackIdx,
  output logic [DATA_W-1:0] stackData,
  output logic              srOutValid,
  output logic [15:0]       srOut,
  output logic              redirect,
  output logic [7:0]        redirectVector,
  output logic              stopEnter,
  output logic              busy
);
  seq_ctl_t ctl;

  tfx_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .retireValid (retireValid),
    .retireClass (retireClass),
    .fmtErr      (fmtErr),
    .traceBits   (srIn[T1_BIT:T0_BIT]),
    .ctl         (ctl),
    .busy        (busy)
  );

  tfx_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .nextPc    (retireNextPc),
    .curPc     (retireCurPc),
    .stopSr    (stopNewSr),
    .srIn      (srIn),
    .stackData (stackData),
    .srOut     (srOut),
    .vecOut    (redirectVector)
  );

  assign stackWe    = ctl.we;
  assign stackIdx   = ctl.wordIdx;
  assign srOutValid = ctl.srPulse;
  assign redirect   = ctl.jump;
  assign stopEnter  = ctl.stopPulse;

  // R6: new status register is supervisor with tracing off
  p_sr_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    srOutValid |-> srOut[S_BIT] && !srOut[T1_BIT] && !srOut[T0_BIT]);

  // R4: word 1 follows word 0
  p_word_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stackWe && stackIdx == 2'd1) |-> $past(stackWe && stackIdx == 2'd0));

  // R1 / R8: at most one of the three event outputs per cycle
  p_one_event_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stackWe, redirect, stopEnter}));
endmodule

// File: tb/sim_trace_fmt_seq.sv
module sim_trace_fmt_seq;
  logic        clk = 1'b0;
  logic        rstN;
  logic        retireValid;
  logic [1:0]  retireClass;
  logic [31:0] retireNextPc, retireCurPc;
  logic [15:0] stopNewSr, srIn;
  logic        fmtErr;
  logic        stackWe, srOutValid, redirect, stopEnter, busy;
  logic [1:0]  stackIdx;
  logic [31:0] stackData;
  logic [15:0] srOut;
  logic [7:0]  redirectVector;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  trace_fmt_seq u0 (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] liveSr(logic [15:0] c);
    return (c & 16'h3FFF) | 16'h2000;
  endfunction

  // drive one retire at a negedge; returns at the next negedge (first word slot)
  task automatic issue(logic [1:0] cls, logic [15:0] sr, logic [31:0] nxt,
                       logic [31:0] cur, logic [15:0] nsr, logic fe);
    @(negedge clk);
    retireValid = 1'b1; retireClass = cls; srIn = sr;
    retireNextPc = nxt; retireCurPc = cur; stopNewSr = nsr; fmtErr = fe;
    @(negedge clk);
    retireValid = 1'b0; fmtErr = 1'b0;
  endtask

  task automatic expectFrame(string req, logic [15:0] copy, logic [31:0] pc, logic [7:0] vec);
    check({req, " w0 we"}, stackWe, 1);
    check({req, " w0 idx"}, stackIdx, 0);
    check({req, " sr copy"}, stackData, {16'h0, copy});
    check({req, " R6 srOutValid"}, srOutValid, 1);
    check({req, " R6 srOut"}, srOut, liveSr(copy));
    check({req, " busy"}, busy, 1);
    @(negedge clk);
    check({req, " w1"}, {stackWe, stackIdx, srOutValid}, {1'b1, 2'd1, 1'b0});
    check({req, " pc"}, stackData, pc);
    @(negedge clk);
    check({req, " w2"}, {stackWe, stackIdx}, {1'b1, 2'd2});
    check({req, " offset"}, stackData, {22'h0, vec, 2'b00});
    @(negedge clk);
    check({req, " R4 redirect"}, {redirect, stackWe, busy}, {1'b1, 1'b0, 1'b1});
    check({req, " vector"}, redirectVector, vec);
    @(negedge clk);
    check({req, " R4 end"}, {redirect, busy, stackWe}, 3'b000);
  endtask

  task automatic expectQuiet(string req, logic stopExp);
    check({req, " stopEnter"}, stopEnter, stopExp);
    check({req, " no write"}, stackWe, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check({req, " quiet"}, {stackWe, redirect, stopEnter, busy}, 4'b0000);
    end
  endtask

  task automatic tReset();
    check("R1 reset outputs", {stackWe, srOutValid, redirect, stopEnter, busy}, 5'b0);
  endtask

  task automatic tTraceModes();
    for (int tb = 0; tb < 4; tb++) begin
      for (int c = 0; c < 2; c++) begin
        logic [15:0] sr;
        logic hit;
        sr = {tb[1:0], 14'h0715};
        hit = (tb == 2) || (tb == 1 && c == 1);
        issue(c[1:0], sr, 32'h1000 + 32'(tb * 16 + c * 4), 32'h0F00, 16'h0, 1'b0);
        if (hit) expectFrame("R2 R5 trace", sr, 32'h1000 + 32'(tb * 16 + c * 4), 8'd9);
        else expectQuiet("R2 no trace", 1'b0);
      end
    end
  endtask

  task automatic tIllegal();
    for (int tb = 0; tb < 4; tb++) begin
      issue(2'd3, {tb[1:0], 14'h0001}, 32'h2004, 32'h2000, 16'h0, 1'b0);
      expectQuiet("R3 illegal", 1'b0);
    end
  endtask

  task automatic tStop();
    issue(2'd2, 16'h2700, 32'h3004, 32'h3000, 16'h2300, 1'b0);
    expectQuiet("R8 stop untraced", 1'b1);
    issue(2'd2, 16'hC000, 32'h3104, 32'h3100, 16'h8015, 1'b0);
    expectFrame("R7 stop t3", 16'h8015, 32'h3104, 8'd9);
    issue(2'd2, 16'h4000, 32'h3204, 32'h3200, 16'h0412, 1'b0);
    expectFrame("R7 stop t1", 16'h0412, 32'h3204, 8'd9);
  endtask

  task automatic tFormat();
    issue(2'd0, 16'h0123, 32'h4004, 32'h4000, 16'h0, 1'b1);
    expectFrame("R9 format", 16'h0123, 32'h4000, 8'd14);
    issue(2'd1, 16'h8321, 32'h4104, 32'h4100, 16'h0, 1'b1);
    expectFrame("R10 format wins", 16'h8321, 32'h4100, 8'd14);
    expectQuiet("R10 no trace after", 1'b0);
    issue(2'd2, 16'hC000, 32'h4204, 32'h4200, 16'h8015, 1'b1);
    expectFrame("R9 R10 stop format", 16'hC000, 32'h4200, 8'd14);
  endtask

  task automatic tBusy();
    issue(2'd0, 16'h8000, 32'h5004, 32'h5000, 16'h0, 1'b0);
    check("R11 w0 before", stackData, 32'h8000);
    retireValid = 1'b1; retireClass = 2'd1; fmtErr = 1'b1;
    srIn = 16'h8000; retireCurPc = 32'h5555; retireNextPc = 32'h6666;
    @(negedge clk);
    retireValid = 1'b0; fmtErr = 1'b0;
    check("R11 pc kept", stackData, 32'h5004);
    @(negedge clk);
    check("R11 vector kept", stackData, 32'd36);
    @(negedge clk);
    check("R11 redirect", {redirect, redirectVector}, {1'b1, 8'd9});
    @(negedge clk);
    expectQuiet("R11 no second frame", 1'b0);
    @(negedge clk);
    fmtErr = 1'b1; srIn = 16'h8000;
    @(negedge clk);
    fmtErr = 1'b0;
    expectQuiet("R11 bare fmtErr", 1'b0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish();
  end

  initial begin
    rstN = 1'b0; retireValid = 1'b0; retireClass = 2'd0; fmtErr = 1'b0;
    retireNextPc = '0; retireCurPc = '0; stopNewSr = '0; srIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tTraceModes();
    tIllegal();
    tStop();
    tFormat();
    tBusy();
    finish();
  end
endmodule